// File: doc/BRIEF.md
# Byte ALU with Status Flag Update

This block is the arithmetic core of a small 8-bit processor. Each request carries an opcode, two byte operands and the current status byte. The block returns a result byte, and a second byte for multiply. It also returns write strobes for the destination registers and the status byte to be written back. Each operation updates only its own subset of flags. All other status bits, including the two top bits (global interrupt enable and bit-copy storage), come back exactly as they were supplied. Handling those two bits and saving or restoring the status byte are left to surrounding logic.

Single-cycle operations register their outputs at the edge that accepts them. Multiply is a two-cycle operation. While a multiply finishes, the block lowers its ready output, and a request presented in that cycle is dropped.

Status byte layout, bit 7 down to bit 0: I, T, H (half carry), S (sign), V (two's-complement overflow), N (negative), Z (zero), C (carry).

Opcode encoding: 0 add, 1 subtract, 2 compare, 3 compare with immediate, 4 AND, 5 shift left, 6 increment, 7 clear, 8 move, 9 load immediate, 10 unsigned multiply, 11 to 15 unused.

Top module: `alu8_flags`

## Requirements
- R1: While reset is asserted, and after its release, `outValid`, `writeEn` and `writeHiEn` are 0, `resultLo`, `resultHi` and `flagsOut` are 0, and `opReady` is 1.
- R2: A request accepted at a clock edge (`opValid` high while `opReady` is high) with a single-cycle opcode (0 to 9) raises `outValid` for one cycle, directly after that edge.
- R3: Add (0) returns A+B modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when both operands have the same sign and the result's sign differs. `writeEn` is 1.
- R4: Subtract (1) returns A−B modulo 256. C is set when A < B unsigned, H is set when A[3:0] < B[3:0], and V is the signed overflow of A−B. Compare (2) and compare with immediate (3) set the same flags with `writeEn` 0.
- R5: For every operation that updates them, N equals bit 7 of the result, Z is 1 exactly when the result is zero, and S equals N XOR V.
- R6: AND (4) clears V and updates S, N, Z. Shift left (5) returns A<<1, with C = A[7], H = A[3] and V = N XOR C. Increment (6) returns A+1 with V set only for A = 0x7F, and leaves C and H unchanged. Clear (7) returns 0 with Z = 1 and N = V = S = 0.
- R7: Move (8) and load immediate (9) return operand B with `writeEn` 1 and leave every status bit unchanged.
- R8: Multiply (10) places the unsigned 16-bit product A×B on `resultHi:resultLo` with `writeEn` and `writeHiEn` both 1, two cycles after acceptance. Z is set when the full product is zero, C equals product bit 15, and all other status bits are unchanged.
- R9: In the cycle after a multiply is accepted, `opReady` is 0 and `outValid` is 0. A request presented in that cycle is ignored.
- R10: Status bits 7 and 6, and any bit outside an operation's affected set, pass from `flagsIn` to `flagsOut` unchanged.
- R11: Unused opcodes (11 to 15) raise `outValid` with `writeEn` and `writeHiEn` 0 and return `flagsIn` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Request strobe |
| opCode | input | 4 | Operation select |
| operandA | input | 8 | Destination-register operand |
| operandB | input | 8 | Source-register or immediate operand |
| flagsIn | input | 8 | Current status byte |
| opReady | output | 1 | Low while a multiply completes |
| outValid | output | 1 | Result and status are valid this cycle |
| writeEn | output | 1 | Write `resultLo` to the destination |
| writeHiEn | output | 1 | Write `resultHi` (multiply high byte) |
| resultLo | output | 8 | Result or low product byte |
| resultHi | output | 8 | High product byte |
| flagsOut | output | 8 | Next status byte |

## Verification
Single-cycle results are due one clock edge after the accepting edge, and multiply results one edge later. The bench drives inputs on the falling edge and samples on the next falling edge, or on the one after for multiply. At the intermediate falling edge of a multiply it checks that `opReady` and `outValid` are low. A request is injected into that busy cycle to show that it produces no output.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 8;
  localparam int MSB    = DATA_W - 1;
  localparam int NIB    = DATA_W / 2 - 1;

  localparam int FLAG_I = 7;
  localparam int FLAG_T = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_S = 4;
  localparam int FLAG_V = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_CPI = 4'd3,
    OP_AND = 4'd4,
    OP_LSL = 4'd5,
    OP_INC = 4'd6,
    OP_CLR = 4'd7,
    OP_MOV = 4'd8,
    OP_LDI = 4'd9,
    OP_MUL = 4'd10
  } aluOp_e;

  localparam logic [FLAG_W-1:0] MASK_ARITH = 8'h3F;
  localparam logic [FLAG_W-1:0] MASK_LOGIC = 8'h1E;
  localparam logic [FLAG_W-1:0] MASK_MUL   = 8'h03;
  localparam logic [FLAG_W-1:0] MASK_NONE  = 8'h00;

  typedef struct packed {
    logic              fire;
    logic              startMul;
    logic              endMul;
    logic              writeRes;
    logic [FLAG_W-1:0] flagMask;
    logic [OP_W-1:0]   op;
  } ctrlStrobe_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output logic            opReady,
  output ctrlStrobe_t     strobe
);
  logic mulPending;
  logic accept;
  logic isMul;

  assign opReady = !mulPending;
  assign accept  = opValid && !mulPending;
  assign isMul   = (opCode == OP_MUL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mulPending <= 1'b0;
    else       mulPending <= accept && isMul;
  end

  always_comb begin
    strobe.fire     = accept && !isMul;
    strobe.startMul = accept && isMul;
    strobe.endMul   = mulPending;
    strobe.op       = opCode;
    strobe.writeRes = 1'b0;
    strobe.flagMask = MASK_NONE;
    case (opCode)
      OP_ADD, OP_SUB, OP_LSL: begin
        strobe.writeRes = 1'b1;
        strobe.flagMask = MASK_ARITH;
      end
      OP_CMP, OP_CPI: strobe.flagMask = MASK_ARITH;
      OP_AND, OP_INC, OP_CLR: begin
        strobe.writeRes = 1'b1;
        strobe.flagMask = MASK_LOGIC;
      end
      OP_MOV, OP_LDI: strobe.writeRes = 1'b1;
      OP_MUL: begin
        strobe.writeRes = 1'b1;
        strobe.flagMask = MASK_MUL;
      end
      default: ;
    endcase
  end

  p_busy_after_mul_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startMul |=> !opReady);
  p_busy_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    mulPending |=> !mulPending);
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              outValid,
  output logic              writeEn,
  output logic              writeHiEn,
  output logic [DATA_W-1:0] resultLo,
  output logic [DATA_W-1:0] resultHi,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   addFull;
  logic [DATA_W:0]   subFull;
  logic [DATA_W-1:0] aluRes;
  logic              hBit, vBit, cBit, nBit, zBit, sBit;
  logic [FLAG_W-1:0] computed;
  logic [FLAG_W-1:0] flagsNext;

  logic [DATA_W-1:0] mulA, mulB;
  logic [FLAG_W-1:0] mulFlags;
  logic [PROD_W-1:0] product;
  logic [FLAG_W-1:0] mulFlagsNext;

  assign addFull = {1'b0, operandA} + {1'b0, operandB};
  assign subFull = {1'b0, operandA} - {1'b0, operandB};

  always_comb begin
    aluRes = '0;
    hBit   = 1'b0;
    vBit   = 1'b0;
    cBit   = 1'b0;
    case (strobe.op)
      OP_ADD: begin
        aluRes = addFull[DATA_W-1:0];
        cBit   = addFull[DATA_W];
        hBit   = (operandA[NIB] & operandB[NIB]) | (operandB[NIB] & ~aluRes[NIB])
               | (~aluRes[NIB] & operandA[NIB]);
        vBit   = (operandA[MSB] & operandB[MSB] & ~aluRes[MSB])
               | (~operandA[MSB] & ~operandB[MSB] & aluRes[MSB]);
      end
      OP_SUB, OP_CMP, OP_CPI: begin
        aluRes = subFull[DATA_W-1:0];
        cBit   = subFull[DATA_W];
        hBit   = (~operandA[NIB] & operandB[NIB]) | (operandB[NIB] & aluRes[NIB])
               | (aluRes[NIB] & ~operandA[NIB]);
        vBit   = (operandA[MSB] & ~operandB[MSB] & ~aluRes[MSB])
               | (~operandA[MSB] & operandB[MSB] & aluRes[MSB]);
      end
      OP_AND: aluRes = operandA & operandB;
      OP_LSL: begin
        aluRes = {operandA[DATA_W-2:0], 1'b0};
        cBit   = operandA[MSB];
        hBit   = operandA[NIB];
        vBit   = aluRes[MSB] ^ operandA[MSB];
      end
      OP_INC: begin
        aluRes = operandA + 1'b1;
        vBit   = (aluRes == {1'b1, {(DATA_W-1){1'b0}}});
      end
      OP_CLR: aluRes = '0;
      OP_MOV, OP_LDI: aluRes = operandB;
      default: aluRes = '0;
    endcase
    nBit = aluRes[MSB];
    zBit = (aluRes == '0);
    sBit = nBit ^ vBit;
    computed = '0;
    computed[FLAG_H] = hBit;
    computed[FLAG_S] = sBit;
    computed[FLAG_V] = vBit;
    computed[FLAG_N] = nBit;
    computed[FLAG_Z] = zBit;
    computed[FLAG_C] = cBit;
    flagsNext = (flagsIn & ~strobe.flagMask) | (computed & strobe.flagMask);
  end

  assign product = mulA * mulB;
  always_comb begin
    mulFlagsNext         = mulFlags;
    mulFlagsNext[FLAG_Z] = (product == '0);
    mulFlagsNext[FLAG_C] = product[PROD_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulA     <= '0;
      mulB     <= '0;
      mulFlags <= '0;
    end else if (strobe.startMul) begin
      mulA     <= operandA;
      mulB     <= operandB;
      mulFlags <= flagsIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      writeEn   <= 1'b0;
      writeHiEn <= 1'b0;
      resultLo  <= '0;
      resultHi  <= '0;
      flagsOut  <= '0;
    end else if (strobe.endMul) begin
      outValid  <= 1'b1;
      writeEn   <= 1'b1;
      writeHiEn <= 1'b1;
      resultLo  <= product[DATA_W-1:0];
      resultHi  <= product[PROD_W-1:DATA_W];
      flagsOut  <= mulFlagsNext;
    end else if (strobe.fire) begin
      outValid  <= 1'b1;
      writeEn   <= strobe.writeRes;
      writeHiEn <= 1'b0;
      resultLo  <= aluRes;
      resultHi  <= '0;
      flagsOut  <= flagsNext;
    end else begin
      outValid  <= 1'b0;
      writeEn   <= 1'b0;
      writeHiEn <= 1'b0;
    end
  end

  p_sign_rule_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && strobe.flagMask[FLAG_S]
      |=> flagsOut[FLAG_S] == (flagsOut[FLAG_N] ^ flagsOut[FLAG_V]));
  p_zero_rule_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && strobe.flagMask[FLAG_Z]
      |=> flagsOut[FLAG_Z] == (resultLo == '0));
  p_top_bits_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> flagsOut[FLAG_I:FLAG_T] == $past(flagsIn[FLAG_I:FLAG_T]));
  p_compare_no_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && !strobe.writeRes |=> !writeEn);
  p_mul_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startMul |=> !outValid);
  p_mul_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.endMul |=> outValid && writeHiEn && writeEn);
  p_single_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> outValid && !writeHiEn);
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              opReady,
  output logic              outValid,
  output logic              writeEn,
  output logic              writeHiEn,
  output logic [DATA_W-1:0] resultLo,
  output logic [DATA_W-1:0] resultHi,
  output logic [FLAG_W-1:0] flagsOut
);
  ctrlStrobe_t strobe;

  alu8_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .opReady (opReady),
    .strobe  (strobe)
  );

  alu8_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operandA  (operandA),
    .operandB  (operandB),
    .flagsIn   (flagsIn),
    .outValid  (outValid),
    .writeEn   (writeEn),
    .writeHiEn (writeHiEn),
    .resultLo  (resultLo),
    .resultHi  (resultHi),
    .flagsOut  (flagsOut)
  );
endmodule

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] operandA = '0, operandB = '0, flagsIn = '0;
  logic       opReady, outValid, writeEn, writeHiEn;
  logic [7:0] resultLo, resultHi, flagsOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .operandA(operandA), .operandB(operandB), .flagsIn(flagsIn),
    .opReady(opReady), .outValid(outValid), .writeEn(writeEn),
    .writeHiEn(writeHiEn), .resultLo(resultLo), .resultHi(resultHi),
    .flagsOut(flagsOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1, 4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10: return "R8";
      default: return "R11";
    endcase
  endfunction

  // Reference model built from the requirement text
  task automatic refModel(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] f, output logic wLo, output logic wHi,
                          output logic [15:0] res, output logic [7:0] fo);
    int sa, sb, sr;
    logic [7:0] r;
    logic h, v, c, n, z;
    logic [15:0] p;
    sa = int'($signed(a));
    sb = int'($signed(b));
    wLo = 1'b0; wHi = 1'b0; res = '0; fo = f;
    r = '0; h = f[5]; v = f[3]; c = f[0];
    case (op)
      4'd0: begin
        r = a + b; c = (int'(a) + int'(b)) > 255; h = (int'(a[3:0]) + int'(b[3:0])) > 15;
        sr = sa + sb; v = (sr > 127) || (sr < -128); wLo = 1'b1;
      end
      4'd1, 4'd2, 4'd3: begin
        r = a - b; c = a < b; h = a[3:0] < b[3:0];
        sr = sa - sb; v = (sr > 127) || (sr < -128); wLo = (op == 4'd1);
      end
      4'd4: begin r = a & b; v = 1'b0; wLo = 1'b1; end
      4'd5: begin r = a << 1; c = a[7]; h = a[3]; v = r[7] ^ a[7]; wLo = 1'b1; end
      4'd6: begin r = a + 8'd1; v = (a == 8'h7F); wLo = 1'b1; end
      4'd7: begin r = 8'h00; v = 1'b0; wLo = 1'b1; end
      4'd8, 4'd9: begin r = b; wLo = 1'b1; end
      4'd10: begin
        p = 16'(a) * 16'(b); wLo = 1'b1; wHi = 1'b1; res = p;
        fo[1] = (p == 16'h0); fo[0] = p[15];
      end
      default: ;
    endcase
    if (op <= 4'd9) begin
      res = {8'h00, r};
      n = r[7]; z = (r == 8'h00);
      if (op <= 4'd7) begin
        fo[4] = n ^ v; fo[3] = v; fo[2] = n; fo[1] = z;
      end
      if (op <= 4'd3 || op == 4'd5) begin
        fo[5] = h; fo[0] = c;
      end
    end
  endtask

  task automatic checkOutputs(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                              input logic [7:0] f);
    logic wLo, wHi;
    logic [15:0] res;
    logic [7:0] fo;
    string rq;
    refModel(op, a, b, f, wLo, wHi, res, fo);
    rq = reqOf(op);
    check(outValid === 1'b1, (op == 4'd10) ? "R8" : "R2", "outValid", 16'(outValid), 16'd1);
    check(writeEn === wLo, rq, "writeEn", 16'(writeEn), 16'(wLo));
    check(writeHiEn === wHi, rq, "writeHiEn", 16'(writeHiEn), 16'(wHi));
    if (wLo) check(resultLo === res[7:0], rq, "resultLo", 16'(resultLo), 16'(res[7:0]));
    if (wHi) check(resultHi === res[15:8], rq, "resultHi", 16'(resultHi), 16'(res[15:8]));
    check(flagsOut === fo, rq, "flagsOut", 16'(flagsOut), 16'(fo));
    check(flagsOut[7:6] === f[7:6], "R10", "top status bits", 16'(flagsOut[7:6]), 16'(f[7:6]));
    if (op <= 4'd7)
      check(flagsOut[4] === (flagsOut[2] ^ flagsOut[3]), "R5", "S=N^V",
            16'(flagsOut[4]), 16'(flagsOut[2] ^ flagsOut[3]));
  endtask

  task automatic runOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] f);
    @(negedge clk);
    opValid = 1'b1; opCode = op; operandA = a; operandB = b; flagsIn = f;
    @(negedge clk);
    opValid = 1'b0;
    if (op == 4'd10) begin
      check(opReady === 1'b0, "R9", "opReady during multiply", 16'(opReady), 16'd0);
      check(outValid === 1'b0, "R9", "outValid during multiply", 16'(outValid), 16'd0);
      @(negedge clk);
    end
    checkOutputs(op, a, b, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(opReady === 1'b1 && outValid === 1'b0 && writeEn === 1'b0 && writeHiEn === 1'b0,
          "R1", "control outputs in reset", {12'h0, opReady, outValid, writeEn, writeHiEn}, 16'h8);
    check(resultLo === 8'h00 && resultHi === 8'h00 && flagsOut === 8'h00, "R1", "data in reset",
          {resultHi, resultLo}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && opReady === 1'b1, "R1", "after release",
          {14'h0, opReady, outValid}, 16'h2);

    // R3 corner cases: carry, half carry, overflow
    runOp(4'd0, 8'hFF, 8'h01, 8'h00);
    runOp(4'd0, 8'h7F, 8'h01, 8'hC0);
    runOp(4'd0, 8'h80, 8'h80, 8'h00);
    // R4: borrow, overflow, compare keeps destination
    runOp(4'd1, 8'h00, 8'h01, 8'h00);
    runOp(4'd1, 8'h80, 8'h01, 8'h3F);
    runOp(4'd2, 8'h10, 8'h10, 8'h00);
    runOp(4'd3, 8'h05, 8'h80, 8'h40);
    // R6 corners
    runOp(4'd4, 8'hF0, 8'h0F, 8'h08);
    runOp(4'd5, 8'hC8, 8'h00, 8'h00);
    runOp(4'd5, 8'h40, 8'h00, 8'h00);
    runOp(4'd6, 8'h7F, 8'h00, 8'h21);
    runOp(4'd6, 8'hFF, 8'h00, 8'h00);
    runOp(4'd7, 8'h93, 8'h00, 8'hFF);
    // R7: move and load immediate keep all flags
    runOp(4'd8, 8'h00, 8'hA5, 8'h5A);
    runOp(4'd9, 8'h00, 8'h00, 8'hFF);
    // R8: multiply corners
    runOp(4'd10, 8'hFF, 8'hFF, 8'hC4);
    runOp(4'd10, 8'h00, 8'h37, 8'h00);
    runOp(4'd10, 8'h10, 8'h10, 8'hFF);
    // R11: unused opcode
    runOp(4'd12, 8'h12, 8'h34, 8'h9C);

    // R9: request in the busy cycle is dropped
    @(negedge clk);
    opValid = 1'b1; opCode = 4'd10; operandA = 8'h0C; operandB = 8'h0D; flagsIn = 8'h00;
    @(negedge clk);
    opCode = 4'd0; operandA = 8'h01; operandB = 8'h01; flagsIn = 8'h00;
    check(opReady === 1'b0, "R9", "opReady busy", 16'(opReady), 16'd0);
    @(negedge clk);
    opValid = 1'b0;
    checkOutputs(4'd10, 8'h0C, 8'h0D, 8'h00);
    @(negedge clk);
    check(outValid === 1'b0, "R9", "dropped request produced output", 16'(outValid), 16'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      runOp(op, 8'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule